// File: doc/BRIEF.md
# Oscilloscope Trace Pixel Renderer

This block produces the colour of every pixel on a 640x480 oscilloscope screen. A raster timing generator supplies a pixel coordinate on every pixel clock. One pixel clock later the block returns a 10-bit red, green and blue value for that coordinate. The screen shows the captured waveform, one 8-bit sample per screen column. Each sample is drawn as a dot, and a vertical run joins each dot to the dot in the previous column. The screen also carries a red horizontal line at the trigger level, a green vertical line at the trigger column, and a dim grey reference grid. Outside the visible area the output is black.

The samples come from a 640-entry by 8-bit line memory inside the block. The memory is loaded from the capture engine's sample array only during vertical sync, so the picture never changes part way through a frame. While vertical sync is high and the capture engine signals that it is in its copy state, a copy index walks from 0 to 639, one entry per clock. When the last entry has been written, a done flag is raised for a single cycle. A restart input clears both the flag and the index at any time. The capture engine drives restart on a run/stop change or a settings change.

Top module: `scope_pixel_render`

## Requirements
- R1: After reset, `copy_done` is 0 and `cap_addr` is 0. The pixel pipeline holds coordinate (0,0) with a stored sample of 0.
- R2: The colour for the coordinate on `pix_x`/`pix_y` in one clock cycle appears on `red`/`green`/`blue` in the following cycle, and stays there until the next clock edge.
- R3: A visible pixel whose row equals 360 minus the sample stored for its column is white, with all three channels at 0x3FF.
- R4: A visible pixel lies strictly between the row of its column's sample and the row of the previous coordinate's sample, in either direction. Such a pixel is white (0x3FF on all channels). The previous coordinate is the one presented one clock earlier.
- R5: A visible pixel on row 360 minus `trig_level` is red: red 0x3FF, green 0, blue 0.
- R6: A visible pixel whose column equals `trig_col` is green: red 0, green 0x3FF, blue 0.
- R7: When several of these apply, the order of precedence is as follows. A sample dot comes first, then a joining run, then the trigger level, then the trigger column, then the grid, and black last.
- R8: Grid pixels are 0x0FF on all three channels. Grid columns are the multiples of 64 from 0 to 576. Grid rows are 104, 136, ..., 360, every 32 rows.
- R9: A visible pixel that matches none of the above is black. Any coordinate with x >= 640 or y >= 480 is black.
- R10: In the cycles where `vsync_active` and `copy_req` are both 1 (and neither restart nor done applies), each clock edge does two things. It writes `cap_data` into the line memory at index `cap_addr`, and it advances `cap_addr` by one.
- R11: The edge that writes index 639 sets `copy_done` to 1 and returns `cap_addr` to 0. `copy_done` is 1 for exactly one cycle.
- R12: `restart` clears `copy_done` and `cap_addr` at the next edge. Outside the copy window `cap_addr` holds its value and the line memory is not written, whatever `cap_data` carries.
- R13: The sample used for a displayed pixel at column x is the entry written at index x by the most recent copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | 10 | Requested pixel column |
| pix_y | input | 10 | Requested pixel row |
| vsync_active | input | 1 | High during vertical sync |
| copy_req | input | 1 | Capture engine is in its copy state |
| restart | input | 1 | Run/stop or settings change: abort and clear the copy |
| cap_data | input | 8 | Capture array entry at index `cap_addr` |
| trig_level | input | 8 | Trigger level sample value |
| trig_col | input | 10 | Trigger position column |
| cap_addr | output | 10 | Copy index into the capture array |
| copy_done | output | 1 | One-cycle pulse when the copy is complete |
| red | output | 10 | Red channel |
| green | output | 10 | Green channel |
| blue | output | 10 | Blue channel |

## Verification
The hardest case to reach from the ports is a pixel where several drawing layers coincide. Examples are a sample dot that sits on the trigger-level row inside the trigger column, or a joining run that crosses a grid row. These need both the loaded memory contents and the trigger settings arranged to meet at one pixel.

The stimulus copies in a seeded random line with forced extremes (0 and 255 next to each other). It then sets the trigger level equal to the sample stored at the trigger column. Full scans follow of that column, the trigger row and two grid rows, mixed with random pixels weighted toward the trace rows. A second copy is started and aborted by restart. The bench first confirms that sync-only and copy-request-only cycles leave the displayed trace unchanged.

// File: rtl/scope_render_pkg.sv
// Shared constants and types for the scope pixel renderer.
// Assumes a 10-bit per channel colour output.
package scope_render_pkg;

    localparam int COLOR_W = 10;
    localparam logic [COLOR_W-1:0] COL_FULL = 10'h3FF;
    localparam logic [COLOR_W-1:0] COL_DIM  = 10'h0FF;
    localparam logic [COLOR_W-1:0] COL_OFF  = 10'h000;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } rgb_t;

    // Pixel classes in descending priority
    typedef enum logic [2:0] {
        PIX_DOT    = 3'd0,
        PIX_JOIN   = 3'd1,
        PIX_TLEVEL = 3'd2,
        PIX_TCOL   = 3'd3,
        PIX_GRID   = 3'd4,
        PIX_BLACK  = 3'd5
    } pix_class_e;

endpackage

// File: rtl/scope_line_mem.sv
// Single-port line memory holding one sample per screen column.
// Synchronous write, registered read; addresses at or beyond DEPTH
// are not written and read back as zero.
module scope_line_mem #(
    parameter int DEPTH  = 640,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];
    logic              addr_ok;

    assign addr_ok = (int'(addr) < DEPTH);

    // Array write port
    always_ff @(posedge clk) begin
        if (we && addr_ok) begin
            store[addr] <= wdata;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= addr_ok ? store[addr] : '0;
        end
    end

endmodule

// File: rtl/scope_copy_ctrl.sv
// Copy sequencer: walks an index across the line memory during the
// vertical-sync copy window, pulses done after the last entry, and
// muxes the memory address between the copy index and the raster x.
// Assumes the capture engine leaves its copy state on seeing done.
module scope_copy_ctrl #(
    parameter int DEPTH  = 640,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_active,
    input  logic              copy_req,
    input  logic              restart,
    input  logic [ADDR_W-1:0] pix_x,
    output logic [ADDR_W-1:0] copy_idx,
    output logic              copy_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    logic copy_win;

    assign copy_win = vsync_active && copy_req;

    // Index and done-flag sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_idx  <= '0;
            copy_done <= 1'b0;
        end else if (restart) begin
            copy_idx  <= '0;
            copy_done <= 1'b0;
        end else if (copy_done) begin
            copy_done <= 1'b0;
        end else if (copy_win) begin
            if (copy_idx == LAST_IDX) begin
                copy_idx  <= '0;
                copy_done <= 1'b1;
            end else begin
                copy_idx  <= copy_idx + 1'b1;
            end
        end
    end

    // Memory port steering
    always_comb begin
        mem_we   = copy_win && !restart && !copy_done;
        mem_addr = copy_win ? copy_idx : pix_x;
    end

endmodule

// File: rtl/scope_pixel_classify.sv
// Combinational pixel classifier and colour mapper. Takes the
// registered coordinate with its sample and the previous sample, and
// picks the highest-priority drawing layer that covers the pixel.
// Assumes trigger settings are steady over a frame.
module scope_pixel_classify
    import scope_render_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 480,
    parameter int COORD_W    = 10,
    parameter int SAMPLE_W   = 8,
    parameter int ZERO_ROW   = 360,
    parameter int GRID_XSTEP = 64,
    parameter int GRID_YSTEP = 32,
    parameter int GRID_YTOP  = 104,
    parameter int GRID_YBOT  = 360
) (
    input  logic [COORD_W-1:0]  px,
    input  logic [COORD_W-1:0]  py,
    input  logic [SAMPLE_W-1:0] cur_s,
    input  logic [SAMPLE_W-1:0] prev_s,
    input  logic [SAMPLE_W-1:0] trig_level,
    input  logic [COORD_W-1:0]  trig_col,
    output pix_class_e          pclass,
    output rgb_t                rgb
);

    localparam logic [COORD_W-1:0] ZROW = COORD_W'(ZERO_ROW);

    logic [COORD_W-1:0] cur_row, prev_row, lvl_row;
    logic visible, on_dot, on_join, on_lvl, on_tcol, on_gx, on_gy;

    // Plot rows for samples and trigger level
    always_comb begin
        cur_row  = ZROW - COORD_W'(cur_s);
        prev_row = ZROW - COORD_W'(prev_s);
        lvl_row  = ZROW - COORD_W'(trig_level);
    end

    // Layer membership tests
    always_comb begin
        visible = (int'(px) < H_ACTIVE) && (int'(py) < V_ACTIVE);
        on_dot  = (py == cur_row);
        on_join = ((prev_row < py) && (py < cur_row)) ||
                  ((cur_row < py) && (py < prev_row));
        on_lvl  = (py == lvl_row);
        on_tcol = (px == trig_col);
        on_gx   = ((int'(px) % GRID_XSTEP) == 0);
        on_gy   = (int'(py) >= GRID_YTOP) && (int'(py) <= GRID_YBOT) &&
                  (((int'(py) - GRID_YTOP) % GRID_YSTEP) == 0);
    end

    // Priority selection
    always_comb begin
        if (!visible)              pclass = PIX_BLACK;
        else if (on_dot)           pclass = PIX_DOT;
        else if (on_join)          pclass = PIX_JOIN;
        else if (on_lvl)           pclass = PIX_TLEVEL;
        else if (on_tcol)          pclass = PIX_TCOL;
        else if (on_gx || on_gy)   pclass = PIX_GRID;
        else                       pclass = PIX_BLACK;
    end

    // Class to colour
    always_comb begin
        case (pclass)
            PIX_DOT, PIX_JOIN: rgb = '{r: COL_FULL, g: COL_FULL, b: COL_FULL};
            PIX_TLEVEL:        rgb = '{r: COL_FULL, g: COL_OFF,  b: COL_OFF};
            PIX_TCOL:          rgb = '{r: COL_OFF,  g: COL_FULL, b: COL_OFF};
            PIX_GRID:          rgb = '{r: COL_DIM,  g: COL_DIM,  b: COL_DIM};
            default:           rgb = '{r: COL_OFF,  g: COL_OFF,  b: COL_OFF};
        endcase
    end

endmodule

// File: rtl/scope_pixel_render.sv
// Scope screen pixel renderer top. Registers the raster coordinate
// alongside the line-memory read so the colour follows one clock after
// the request, keeps the previous column's sample for joining runs,
// and loads the line memory from the capture array in vertical sync.
// Assumes cap_data is the capture array entry at cap_addr, same cycle.
module scope_pixel_render
    import scope_render_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 480,
    parameter int COORD_W    = 10,
    parameter int SAMPLE_W   = 8,
    parameter int ZERO_ROW   = 360,
    parameter int GRID_XSTEP = 64,
    parameter int GRID_YSTEP = 32,
    parameter int GRID_YTOP  = 104,
    parameter int GRID_YBOT  = 360
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic                vsync_active,
    input  logic                copy_req,
    input  logic                restart,
    input  logic [SAMPLE_W-1:0] cap_data,
    input  logic [SAMPLE_W-1:0] trig_level,
    input  logic [COORD_W-1:0]  trig_col,
    output logic [COORD_W-1:0]  cap_addr,
    output logic                copy_done,
    output logic [9:0]          red,
    output logic [9:0]          green,
    output logic [9:0]          blue
);

    localparam int LINE_DEPTH = H_ACTIVE;

    logic                mem_we;
    logic [COORD_W-1:0]  mem_addr;
    logic [SAMPLE_W-1:0] cur_s;
    logic [SAMPLE_W-1:0] prev_s;
    logic [COORD_W-1:0]  px_q, py_q;
    pix_class_e          pclass;
    rgb_t                rgb;

    scope_copy_ctrl #(
        .DEPTH  (LINE_DEPTH),
        .ADDR_W (COORD_W)
    ) u_copy (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_active (vsync_active),
        .copy_req     (copy_req),
        .restart      (restart),
        .pix_x        (pix_x),
        .copy_idx     (cap_addr),
        .copy_done    (copy_done),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr)
    );

    scope_line_mem #(
        .DEPTH  (LINE_DEPTH),
        .DATA_W (SAMPLE_W),
        .ADDR_W (COORD_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (cap_data),
        .rdata (cur_s)
    );

    // Coordinate pipeline aligned with the memory read, plus prior sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q   <= '0;
            py_q   <= '0;
            prev_s <= '0;
        end else begin
            px_q   <= pix_x;
            py_q   <= pix_y;
            prev_s <= cur_s;
        end
    end

    scope_pixel_classify #(
        .H_ACTIVE   (H_ACTIVE),
        .V_ACTIVE   (V_ACTIVE),
        .COORD_W    (COORD_W),
        .SAMPLE_W   (SAMPLE_W),
        .ZERO_ROW   (ZERO_ROW),
        .GRID_XSTEP (GRID_XSTEP),
        .GRID_YSTEP (GRID_YSTEP),
        .GRID_YTOP  (GRID_YTOP),
        .GRID_YBOT  (GRID_YBOT)
    ) u_cls (
        .px         (px_q),
        .py         (py_q),
        .cur_s      (cur_s),
        .prev_s     (prev_s),
        .trig_level (trig_level),
        .trig_col   (trig_col),
        .pclass     (pclass),
        .rgb        (rgb)
    );

    // Drive colour ports from the classifier result
    always_comb begin
        red   = rgb.r;
        green = rgb.g;
        blue  = rgb.b;
    end

endmodule

// File: rtl/scope_render_checker.sv
// Protocol checker for the scope pixel renderer: copy sequencing,
// done pulse shape, restart behaviour and off-screen blanking.
module scope_render_checker #(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int COORD_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic               vsync_active,
    input logic               copy_req,
    input logic               restart,
    input logic [COORD_W-1:0] cap_addr,
    input logic               copy_done,
    input logic [9:0]         red,
    input logic [9:0]         green,
    input logic [9:0]         blue
);

    localparam logic [COORD_W-1:0] LAST = COORD_W'(H_ACTIVE - 1);

    logic run_q;
    logic win;

    assign win = vsync_active && copy_req;

    // Marks cycles after the first post-reset edge
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    a_r10_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !restart && !copy_done && cap_addr != LAST)
        |=> (cap_addr == $past(cap_addr) + 1'b1) && !copy_done);

    a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !restart && !copy_done && cap_addr == LAST)
        |=> copy_done && cap_addr == '0);

    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !copy_done);

    a_r12_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !copy_done && cap_addr == '0);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !restart && !copy_done) |=> $stable(cap_addr));

    a_r9_blank_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (int'($past(pix_x)) >= H_ACTIVE || int'($past(pix_y)) >= V_ACTIVE))
        |-> (red == '0 && green == '0 && blue == '0));

endmodule

bind scope_pixel_render scope_render_checker #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE),
    .COORD_W  (COORD_W)
) u_render_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .vsync_active (vsync_active),
    .copy_req     (copy_req),
    .restart      (restart),
    .cap_addr     (cap_addr),
    .copy_done    (copy_done),
    .red          (red),
    .green        (green),
    .blue         (blue)
);

// File: tb/scope_pixel_render_bench.sv
// Self-checking bench for the scope pixel renderer.
module scope_pixel_render_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pix_x = '0, pix_y = '0;
    logic       vsync_active = 1'b0, copy_req = 1'b0, restart = 1'b0;
    logic [7:0] cap_data;
    logic [7:0] trig_level = 8'd40;
    logic [9:0] trig_col = 10'd200;
    logic [9:0] cap_addr;
    logic       copy_done;
    logic [9:0] red, green, blue;

    logic [7:0] src_mem [640];
    logic [7:0] model   [640];
    int checks = 0;
    int errors = 0;
    logic [7:0] last_s = 8'd0;
    bit   last_ok = 1'b1;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    assign cap_data = src_mem[cap_addr];

    scope_pixel_render u_scope_pixel_render (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .vsync_active(vsync_active), .copy_req(copy_req), .restart(restart),
        .cap_data(cap_data), .trig_level(trig_level), .trig_col(trig_col),
        .cap_addr(cap_addr), .copy_done(copy_done),
        .red(red), .green(green), .blue(blue)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Expected colour {r,g,b} from the requirements
    function automatic logic [29:0] exp_rgb(input int x, input int y, input int cur,
                                            input int prv, output string tag);
        int cr = 360 - cur;
        int pr = 360 - prv;
        int lr = 360 - int'(trig_level);
        if (x >= 640 || y >= 480) begin tag = "R9 offscreen"; return '0; end
        if (y == cr) begin tag = "R3 dot"; return {10'h3FF, 10'h3FF, 10'h3FF}; end
        if ((pr < y && y < cr) || (cr < y && y < pr)) begin
            tag = "R4 join"; return {10'h3FF, 10'h3FF, 10'h3FF};
        end
        if (y == lr) begin tag = "R5 trig level"; return {10'h3FF, 10'h0, 10'h0}; end
        if (x == int'(trig_col)) begin tag = "R6 trig col"; return {10'h0, 10'h3FF, 10'h0}; end
        if ((x % 64) == 0 || (y >= 104 && y <= 360 && ((y - 104) % 32) == 0)) begin
            tag = "R8 grid"; return {10'h0FF, 10'h0FF, 10'h0FF};
        end
        tag = "R9 black";
        return '0;
    endfunction

    // Present one coordinate at a falling edge, check it one clock later
    task automatic pix(input int x, input int y, input bit do_chk);
        string tag;
        logic [29:0] e;
        int cur;
        pix_x = 10'(x);
        pix_y = 10'(y);
        @(negedge clk);
        cur = (x < 640) ? int'(model[x]) : 0;
        e = exp_rgb(x, y, cur, int'(last_s), tag);
        if (do_chk && (last_ok || x >= 640 || y >= 480))
            chk({tag, " R7 R13"}, {2'b0, red, green, blue}, {2'b0, e});
        last_s  = 8'(cur);
        last_ok = (x < 640);
    endtask

    task automatic full_copy();
        vsync_active = 1'b1; copy_req = 1'b1;
        for (int k = 1; k <= 640; k++) begin
            @(negedge clk);
            if (k == 1)   chk("R10 index after one edge", 32'(cap_addr), 32'd1);
            if (k == 639) begin
                chk("R10 index at last entry", 32'(cap_addr), 32'd639);
                chk("R11 done not early", 32'(copy_done), 32'd0);
            end
        end
        chk("R11 done raised", 32'(copy_done), 32'd1);
        chk("R11 index wraps", 32'(cap_addr), 32'd0);
        vsync_active = 1'b0; copy_req = 1'b0;
        @(negedge clk);
        chk("R11 done one cycle", 32'(copy_done), 32'd0);
        for (int i = 0; i < 640; i++) model[i] = src_mem[i];
        last_ok = 1'b0;
    endtask

    task automatic fill_src(input bit extremes);
        for (int i = 0; i < 640; i++) src_mem[i] = 8'($urandom_range(0, 255));
        if (extremes) begin
            src_mem[0] = 8'd0; src_mem[639] = 8'd255;
            src_mem[320] = 8'd255; src_mem[321] = 8'd0; src_mem[322] = 8'd255;
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 640; i++) begin src_mem[i] = 8'd0; model[i] = 8'd0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done at reset", 32'(copy_done), 32'd0);
        chk("R1 index at reset", 32'(cap_addr), 32'd0);
        chk("R1 colour at reset", {2'b0, red, green, blue}, {2'b0, 10'h0FF, 10'h0FF, 10'h0FF});

        fill_src(1'b1);
        full_copy();

        // R2: dot then black pixel on consecutive clocks
        pix(10, 360 - int'(model[10]), 1'b0);
        pix_x = 10'd11; pix_y = 10'd5;
        chk("R2 colour held before edge", {2'b0, red, green, blue}, {2'b0, 10'h3FF, 10'h3FF, 10'h3FF});
        @(negedge clk);
        chk("R2 next colour after edge", {2'b0, red, green, blue}, 32'd0);
        last_ok = 1'b0;

        // R7: trigger level equals the sample at the trigger column
        trig_col = 10'd130;
        trig_level = model[130];
        for (int y = 0; y < 480; y++) begin
            pix(129, y, 1'b0);
            pix(130, y, 1'b1);
        end
        last_ok = 1'b0;
        for (int x = 0; x < 640; x++) pix(x, 360 - int'(trig_level), 1'b1);
        last_ok = 1'b0;
        for (int x = 0; x < 640; x++) pix(x, 104, 1'b1);
        last_ok = 1'b0;
        for (int x = 0; x < 640; x++) pix(x, 360, 1'b1);
        // R4 steep runs at the forced extremes
        for (int y = 100; y < 365; y++) begin
            pix(320, y, 1'b0); pix(321, y, 1'b1); pix(322, y, 1'b1);
        end
        // R9 off screen
        for (int x = 630; x < 800; x += 3) pix(x, 200, 1'b1);
        for (int y = 470; y < 525; y++) pix(300, y, 1'b1);

        // Random pixels biased to the trace rows
        trig_level = 8'd77; trig_col = 10'd450;
        last_ok = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            int x = int'($urandom_range(0, 639));
            int y;
            if (($urandom & 1) == 1) y = 360 - int'(model[x]) + int'($urandom_range(0, 4)) - 2;
            else y = int'($urandom_range(0, 479));
            pix(x, y, 1'b1);
        end

        // R12: copy window inputs on their own do not write
        fill_src(1'b0);
        vsync_active = 1'b1; copy_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 index holds in sync only", 32'(cap_addr), 32'd0);
        vsync_active = 1'b0; copy_req = 1'b1;
        repeat (20) @(negedge clk);
        chk("R12 index holds in request only", 32'(cap_addr), 32'd0);
        copy_req = 1'b0;
        last_ok = 1'b0;
        for (int x = 0; x < 640; x++) pix(x, 360 - int'(model[x]), 1'b1);

        // R12: restart aborts a copy in progress
        vsync_active = 1'b1; copy_req = 1'b1;
        repeat (100) @(negedge clk);
        chk("R10 partial index", 32'(cap_addr), 32'd100);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R12 restart clears index", 32'(cap_addr), 32'd0);
        chk("R12 restart clears done", 32'(copy_done), 32'd0);
        vsync_active = 1'b0; copy_req = 1'b0;
        @(negedge clk);

        // Fresh line, fully copied, then checked column by column (R13)
        full_copy();
        last_ok = 1'b0;
        for (int x = 0; x < 640; x++) pix(x, 360 - int'(model[x]), 1'b1);
        for (int n = 0; n < 1500; n++) begin
            int x = int'($urandom_range(0, 639));
            pix(x, int'($urandom_range(100, 370)), 1'b1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule